// File: doc/BRIEF.md
# Entropy word distributor with request/acknowledge endpoints

This block sits between a generator of 128-bit random words and four endpoint ports that each take random data 32 bits at a time. A wide word arrives over a valid/ready link and is held in a single-word buffer. It is then cut into four 32-bit slices, and the slices go out one at a time to whichever endpoints are asking for data. While part of a word is still unused, the block pushes back on the upstream link, so no random bits are dropped or handed out twice.

Each endpoint port has a request input and three outputs: an acknowledge, a 32-bit data bus and a compliance flag. The compliance flag travels with the word it came from. When fresh data is placed on a port, acknowledge stays high until the endpoint takes the data. The endpoint takes it by holding request high in a cycle where acknowledge is high. After that the bus keeps its value until the port is served again, so a slow endpoint can still capture it late. Every accepted word also has its low 64 bits compared with those of the word accepted before it. A match gives a one-cycle alert pulse. An enable input stops distribution and throws away any partly used word.

Top module: `ent_word_dist`

## Requirements
- R1: After a synchronous reset, every acknowledge is low, every data bus and compliance flag is zero and the alert is low. Upstream ready is high exactly when the enable is high.
- R2: A word is taken in a cycle where upstream valid and ready are both high. From the next cycle, ready stays low until all four slices of that word have been granted.
- R3: Slices of a word are handed out in rising bit order: the k-th slice granted (k = 0..3) carries bits [32k+31:32k] of the word.
- R4: A port is pending when its request is high and its acknowledge is low. A pending port may be granted a slice only while a buffered word has unused slices. Its acknowledge rises in the cycle after the grant, and its bus and compliance flag then show that slice and the word's flag.
- R5: At most one slice is granted per cycle. Among pending ports, the winner is the first one found searching upward from a pointer, wrapping around. The pointer starts at port 0 after reset and moves to the port after each winner.
- R6: An acknowledge stays high until a cycle in which its request is also high. In the cycle after that, it is low.
- R7: A port's data bus and compliance flag do not change unless that port is granted again, and a grant needs a new request.
- R8: Bits [63:0] of each accepted word are compared with bits [63:0] of the word accepted before it since reset. On a match, the alert is high for exactly the one cycle after acceptance. Bits [127:64] play no part, and the first word after reset never raises the alert.
- R9: While the enable is low, ready is low and no slice is granted. Every acknowledge is low from the next cycle, and the unused rest of the buffered word is dropped. After enable returns, the next slice delivered is slice 0 of a newly accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Distribution enable; low flushes the buffer and clears acknowledges |
| up_valid_i | input | 1 | Upstream word valid |
| up_data_i | input | 128 | Upstream random word |
| up_fips_i | input | 1 | Compliance flag of the upstream word |
| up_ready_o | output | 1 | Block can take an upstream word |
| ep_req_i | input | 4 | Per-port request |
| ep_ack_o | output | 4 | Per-port acknowledge: fresh data on the bus |
| ep_bus_o | output | 128 | Per-port 32-bit data, port p at bits [32p+31:32p] |
| ep_fips_o | output | 4 | Per-port compliance flag of the data on the bus |
| rep_alert_o | output | 1 | One-cycle repeated-value alert |

## Verification
The hardest case to reach is a disable that arrives while a word is only partly used and one port holds an acknowledge it has not consumed. The stimulus builds this on purpose. One endpoint drops its request in the same cycle it sees acknowledge. Enable is then pulled while the buffer still has slices left. The next delivery must be slice 0 of a fresh word, not a leftover slice. Round-robin order is reached by holding all four requests high before a word arrives, with the pointer left at a known, nonzero port by an earlier phase. The alert is driven with word pairs that match only in the compared half and with pairs that match only in the other half.

// File: rtl/ent_dist_pkg.sv
package ent_dist_pkg;

    // Width of one endpoint data slice.
    parameter int SLICE_W = 32;

    // One slice as it travels from the word buffer to a port.
    typedef struct packed {
        logic [SLICE_W-1:0] data;
        logic               fips;
    } ent_slice_t;

    // Next round-robin start after a given winner.
    function automatic int rr_after(input int winner, input int nports);
        return (winner + 1) % nports;
    endfunction

endpackage

// File: rtl/ent_upstream_buf.sv
module ent_upstream_buf
    import ent_dist_pkg::*;
#(
    parameter int SLICES = 4,
    parameter int CMP_W  = 64,
    localparam int WORD_W = SLICES * SLICE_W,
    localparam int IDX_W  = $clog2(SLICES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              up_valid_i,
    input  logic [WORD_W-1:0] up_data_i,
    input  logic              up_fips_i,
    output logic              up_ready_o,
    input  logic              take_i,
    output logic              avail_o,
    output ent_slice_t        slice_o,
    output logic              rep_alert_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLICES - 1);

    logic [WORD_W-1:0] word_q;
    logic              fips_q;
    logic [IDX_W-1:0]  idx_q;
    logic              full_q;
    logic [CMP_W-1:0]  prev_q;
    logic              have_prev_q;
    logic              alert_q;
    logic              accept;
    logic              repeat_hit;

    assign up_ready_o = en_i && !full_q;
    assign accept     = up_valid_i && up_ready_o;
    assign repeat_hit = have_prev_q && (up_data_i[CMP_W-1:0] == prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q      <= '0;
            fips_q      <= 1'b0;
            idx_q       <= '0;
            full_q      <= 1'b0;
            prev_q      <= '0;
            have_prev_q <= 1'b0;
            alert_q     <= 1'b0;
        end else begin
            alert_q <= accept && repeat_hit;
            if (accept) begin
                word_q      <= up_data_i;
                fips_q      <= up_fips_i;
                idx_q       <= '0;
                full_q      <= 1'b1;
                prev_q      <= up_data_i[CMP_W-1:0];
                have_prev_q <= 1'b1;
            end else if (!en_i) begin
                full_q <= 1'b0;
                idx_q  <= '0;
            end else if (take_i && full_q) begin
                idx_q <= idx_q + 1'b1;
                if (idx_q == LAST_IDX) begin
                    full_q <= 1'b0;
                end
            end
        end
    end

    assign avail_o      = full_q;
    assign slice_o.data = word_q[idx_q*SLICE_W +: SLICE_W];
    assign slice_o.fips = fips_q;
    assign rep_alert_o  = alert_q;

endmodule

// File: rtl/ent_rr_arb.sv
module ent_rr_arb
    import ent_dist_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int PTR_W = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] pend_i,
    output logic [NUM_PORTS-1:0] gnt_o,
    output logic                 gnt_any_o
);
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] win;
    logic [PTR_W-1:0] cand;
    logic             found;
    int               k;

    always_comb begin
        gnt_o = '0;
        found = 1'b0;
        win   = '0;
        cand  = '0;
        k     = 0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            k    = (int'(ptr_q) + i) % NUM_PORTS;
            cand = PTR_W'(k);
            if (!found && pend_i[cand]) begin
                found = 1'b1;
                win   = cand;
            end
        end
        gnt_o[win] = found;
    end

    assign gnt_any_o = found;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (found) begin
            ptr_q <= PTR_W'(rr_after(int'(win), NUM_PORTS));
        end
    end

endmodule

// File: rtl/ent_port_hold.sv
module ent_port_hold
    import ent_dist_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en_i,
    input  logic               gnt_i,
    input  logic               req_i,
    input  ent_slice_t         slice_i,
    output logic               ack_o,
    output logic [SLICE_W-1:0] bus_o,
    output logic               fips_o
);
    logic               ack_q;
    logic [SLICE_W-1:0] bus_q;
    logic               fips_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q  <= 1'b0;
            bus_q  <= '0;
            fips_q <= 1'b0;
        end else if (!en_i) begin
            ack_q <= 1'b0;
        end else if (gnt_i) begin
            ack_q  <= 1'b1;
            bus_q  <= slice_i.data;
            fips_q <= slice_i.fips;
        end else if (ack_q && req_i) begin
            ack_q <= 1'b0;
        end
    end

    assign ack_o  = ack_q;
    assign bus_o  = bus_q;
    assign fips_o = fips_q;

endmodule

// File: rtl/ent_word_dist.sv
module ent_word_dist
    import ent_dist_pkg::*;
#(
    parameter int NUM_PORTS       = 4,
    parameter int SLICES_PER_WORD = 4,
    parameter int CMP_W           = 64
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   en_i,
    input  logic                                   up_valid_i,
    input  logic [SLICES_PER_WORD*SLICE_W-1:0]     up_data_i,
    input  logic                                   up_fips_i,
    output logic                                   up_ready_o,
    input  logic [NUM_PORTS-1:0]                   ep_req_i,
    output logic [NUM_PORTS-1:0]                   ep_ack_o,
    output logic [NUM_PORTS*SLICE_W-1:0]           ep_bus_o,
    output logic [NUM_PORTS-1:0]                   ep_fips_o,
    output logic                                   rep_alert_o
);
    localparam int SL_W = SLICE_W;

    ent_slice_t           cur_slice;
    logic                 avail;
    logic [NUM_PORTS-1:0] pend;
    logic [NUM_PORTS-1:0] gnt;
    logic                 gnt_any;

    ent_upstream_buf #(
        .SLICES (SLICES_PER_WORD),
        .CMP_W  (CMP_W)
    ) buf_i (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en_i),
        .up_valid_i  (up_valid_i),
        .up_data_i   (up_data_i),
        .up_fips_i   (up_fips_i),
        .up_ready_o  (up_ready_o),
        .take_i      (gnt_any),
        .avail_o     (avail),
        .slice_o     (cur_slice),
        .rep_alert_o (rep_alert_o)
    );

    // A port competes only when it asks, holds no fresh data, and a word is ready.
    assign pend = ep_req_i & ~ep_ack_o & {NUM_PORTS{avail && en_i}};

    ent_rr_arb #(
        .NUM_PORTS (NUM_PORTS)
    ) arb_i (
        .clk       (clk),
        .rst       (rst),
        .pend_i    (pend),
        .gnt_o     (gnt),
        .gnt_any_o (gnt_any)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        ent_port_hold hold_i (
            .clk     (clk),
            .rst     (rst),
            .en_i    (en_i),
            .gnt_i   (gnt[p]),
            .req_i   (ep_req_i[p]),
            .slice_i (cur_slice),
            .ack_o   (ep_ack_o[p]),
            .bus_o   (ep_bus_o[p*SL_W +: SL_W]),
            .fips_o  (ep_fips_o[p])
        );
    end

endmodule

// File: rtl/ent_word_dist_chk.sv
module ent_word_dist_chk #(
    parameter int NUM_PORTS = 4,
    parameter int SL_W      = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      en_i,
    input logic                      up_valid_i,
    input logic                      up_ready_o,
    input logic [NUM_PORTS-1:0]      ep_req_i,
    input logic [NUM_PORTS-1:0]      ep_ack_o,
    input logic [NUM_PORTS*SL_W-1:0] ep_bus_o,
    input logic                      rep_alert_o
);
    // R2
    accept_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (up_valid_i && up_ready_o) |=> !up_ready_o);

    // R5
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ep_ack_o & ~$past(ep_ack_o)));

    // R8
    alert_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rep_alert_o |=> !rep_alert_o);

    // R9
    disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (ep_ack_o == '0));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pc
        // R6
        ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (en_i && ep_ack_o[p] && !ep_req_i[p]) |=> ep_ack_o[p]);

        // R6
        ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
            (ep_ack_o[p] && ep_req_i[p]) |=> !ep_ack_o[p]);

        // R7
        bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !ep_req_i[p] |=> $stable(ep_bus_o[p*SL_W +: SL_W]));

        // R4
        ack_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(ep_ack_o[p]) |-> $past(ep_req_i[p]));
    end

endmodule

bind ent_word_dist ent_word_dist_chk #(
    .NUM_PORTS (NUM_PORTS),
    .SL_W      (SL_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_i),
    .up_valid_i  (up_valid_i),
    .up_ready_o  (up_ready_o),
    .ep_req_i    (ep_req_i),
    .ep_ack_o    (ep_ack_o),
    .ep_bus_o    (ep_bus_o),
    .rep_alert_o (rep_alert_o)
);

// File: tb/ent_word_dist_tb_top.sv
module ent_word_dist_tb_top;

    typedef struct {
        int          port;
        logic [31:0] data;
        logic        fips;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en_i = 1'b1;
    logic         up_valid_i = 1'b0;
    logic [127:0] up_data_i = '0;
    logic         up_fips_i = 1'b0;
    logic         up_ready_o;
    logic [3:0]   ep_req_i = '0;
    logic [3:0]   ep_ack_o;
    logic [127:0] ep_bus_o;
    logic [3:0]   ep_fips_o;
    logic         rep_alert_o;

    int   n_checks = 0;
    int   n_errors = 0;
    int   alert_cnt = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];
    logic [3:0] ack_prev = '0;
    logic [3:0] rises;

    always #5 clk = ~clk;

    ent_word_dist dut_i (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en_i),
        .up_valid_i  (up_valid_i),
        .up_data_i   (up_data_i),
        .up_fips_i   (up_fips_i),
        .up_ready_o  (up_ready_o),
        .ep_req_i    (ep_req_i),
        .ep_ack_o    (ep_ack_o),
        .ep_bus_o    (ep_bus_o),
        .ep_fips_o   (ep_fips_o),
        .rep_alert_o (rep_alert_o)
    );

    function automatic logic [31:0] sl(input logic [127:0] w, input int k);
        return w[k*32 +: 32];
    endfunction

    task automatic check(input bit ok, input string rq, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic push_exp(input int p, input logic [31:0] d, input logic f);
        exp_t e;
        e.port = p; e.data = d; e.fips = f;
        exp_q.push_back(e);
    endtask

    task automatic send_word(input logic [127:0] d, input logic f);
        @(negedge clk);
        up_valid_i = 1'b1; up_data_i = d; up_fips_i = f;
        #1;
        while (!up_ready_o) begin
            @(negedge clk); #1;
        end
        @(posedge clk); #1;
        up_valid_i = 1'b0;
    endtask

    // Ask once on port p, drop the request in the cycle the ack is seen.
    task automatic fetch_hold(input int p);
        @(negedge clk);
        ep_req_i[p] = 1'b1;
        forever begin
            @(negedge clk);
            if (ep_ack_o[p]) break;
        end
        ep_req_i[p] = 1'b0;
    endtask

    // Monitor: scoreboard pop on every acknowledge rise, alert counting.
    always @(negedge clk) begin
        if (rst) begin
            ack_prev = '0;
        end else begin
            rises = ep_ack_o & ~ack_prev;
            if (rises != '0)
                check($countones(rises) <= 1, "R5 one delivery per cycle",
                      128'(rises), 128'(1));
            for (int p = 0; p < 4; p++) begin
                if (rises[p]) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R4 unexpected delivery", 128'(p), 128'(0));
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(e.port == p, "R5 grant order port",
                              128'(p), 128'(e.port));
                        check(ep_bus_o[p*32 +: 32] == e.data, "R3 R4 slice data",
                              128'(ep_bus_o[p*32 +: 32]), 128'(e.data));
                        check(ep_fips_o[p] == e.fips, "R4 compliance flag",
                              128'(ep_fips_o[p]), 128'(e.fips));
                    end
                end
            end
            ack_prev = ep_ack_o;
            if (rep_alert_o) alert_cnt++;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] w1, w2, w3, w4, w5;
        logic [31:0]  held;
        w1 = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
        w2 = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
        w3 = 128'h9999_aaaa_bbbb_cccc_5555_6666_7777_8888; // same low half as w2
        w4 = 128'hdead_beef_cafe_f00d_0bad_c0de_1357_9bdf;
        w5 = 128'hdead_beef_cafe_f00d_2468_ace0_1122_3344; // same high half as w4

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        check(ep_ack_o == '0, "R1 ack after reset", 128'(ep_ack_o), 0);
        check(ep_bus_o == '0, "R1 bus after reset", ep_bus_o, 0);
        check(ep_fips_o == '0, "R1 flags after reset", 128'(ep_fips_o), 0);
        check(rep_alert_o == 1'b0, "R1 alert after reset", 128'(rep_alert_o), 0);
        check(up_ready_o == 1'b1, "R1 ready with enable", 128'(up_ready_o), 1);

        // R2 back pressure with no requester
        send_word(w1, 1'b1);
        @(negedge clk); #1;
        check(up_ready_o == 1'b0, "R2 ready low after accept", 128'(up_ready_o), 0);
        repeat (5) @(negedge clk);
        #1;
        check(up_ready_o == 1'b0, "R2 ready held low", 128'(up_ready_o), 0);
        check(ep_ack_o == '0, "R4 no delivery without request", 128'(ep_ack_o), 0);
        check(alert_cnt == 0, "R8 first word no alert", 128'(alert_cnt), 0);

        // R3 one port drains the word in rising bit order
        for (int k = 0; k < 4; k++) push_exp(2, sl(w1, k), 1'b1);
        @(negedge clk); ep_req_i[2] = 1'b1;
        repeat (12) @(negedge clk);
        #1;
        check(up_ready_o == 1'b1, "R2 ready after four slices", 128'(up_ready_o), 1);
        check(exp_q.size() == 0, "R3 all slices delivered", 128'(exp_q.size()), 0);
        ep_req_i[2] = 1'b0;
        repeat (3) @(negedge clk);

        // R5 round robin, pointer now at port 3
        for (int k = 0; k < 4; k++) push_exp((3 + k) % 4, sl(w2, k), 1'b0);
        for (int k = 0; k < 4; k++) push_exp((3 + k) % 4, sl(w3, k), 1'b1);
        @(negedge clk); ep_req_i = 4'hf;
        send_word(w2, 1'b0);
        repeat (2) @(negedge clk);
        check(alert_cnt == 0, "R8 distinct low half no alert", 128'(alert_cnt), 0);
        send_word(w3, 1'b1);
        repeat (12) @(negedge clk);
        check(alert_cnt == 1, "R8 repeated low half alerts once", 128'(alert_cnt), 1);
        check(exp_q.size() == 0, "R5 round robin drained", 128'(exp_q.size()), 0);
        ep_req_i = '0;
        repeat (3) @(negedge clk);

        // R6 R7 ack holds until consumed, bus persists after
        send_word(w4, 1'b1);
        push_exp(1, sl(w4, 0), 1'b1);
        fetch_hold(1);
        repeat (5) @(negedge clk);
        #1;
        check(ep_ack_o[1] == 1'b1, "R6 ack held without request", 128'(ep_ack_o[1]), 1);
        held = ep_bus_o[63:32];
        @(negedge clk); ep_req_i[1] = 1'b1;
        @(negedge clk); ep_req_i[1] = 1'b0;
        #1;
        check(ep_ack_o[1] == 1'b0, "R6 ack low after consumption", 128'(ep_ack_o[1]), 0);
        repeat (5) @(negedge clk);
        #1;
        check(ep_bus_o[63:32] == sl(w4, 0), "R7 bus persists", 128'(ep_bus_o[63:32]),
              128'(sl(w4, 0)));
        check(ep_bus_o[63:32] == held, "R7 bus unchanged", 128'(ep_bus_o[63:32]), 128'(held));
        check(ep_fips_o[1] == 1'b1, "R7 flag persists", 128'(ep_fips_o[1]), 1);

        // R9 disable with a partly used word and an unconsumed ack
        push_exp(3, sl(w4, 1), 1'b1);
        fetch_hold(3);
        #1;
        check(ep_ack_o[3] == 1'b1, "R9 ack pending before disable", 128'(ep_ack_o[3]), 1);
        @(negedge clk); en_i = 1'b0;
        #1;
        check(up_ready_o == 1'b0, "R9 ready low while disabled", 128'(up_ready_o), 0);
        @(negedge clk); #1;
        check(ep_ack_o == '0, "R9 acks cleared", 128'(ep_ack_o), 0);
        @(negedge clk); en_i = 1'b1;
        #1;
        check(up_ready_o == 1'b1, "R9 rest of word dropped", 128'(up_ready_o), 1);
        push_exp(0, sl(w5, 0), 1'b0);
        send_word(w5, 1'b0);
        fetch_hold(0);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 fresh slice after enable", 128'(exp_q.size()), 0);
        check(alert_cnt == 1, "R8 high half ignored", 128'(alert_cnt), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule